// File: doc/BRIEF.md
# Block-Buffered Pseudo-DMA Bridge

This block couples a host register bus to a byte-wide SCSI-side data port through one on-board buffer of `BLK_BYTES` bytes (128 by default). Software sets a direction bit in a control/status register and then writes a count of whole blocks. Software computes that count as the byte length shifted right by 7. For each block, software polls a host-buffer-not-ready flag and then moves the block through a memory-mapped window. The SCSI side fills or empties the same buffer with a valid/ready byte handshake. The buffer belongs to one side at a time, and ownership passes back and forth as each block completes.

While a transfer runs, the access-permitted flag is clear. It is set again after the last block, and a gated completion interrupt is raised only when core interrupts are enabled. The SCSI side can pause the handshake to model a disconnect. A write to the resume location restarts the handshake from the current buffer position, and the block count is not reloaded.

Top module: `blkdma_bridge`

Register map: the control/status register is at address 0x00 and the block count at 0x01. A write of any value to 0x02 is the resume command. Addresses with the top address bit set form the data window, with buffer index = low address bits. Control/status bits are as follows. Bit 7 reads as the access-permitted flag; writing 1 to it resets the controller. Bit 6 is the direction, where 1 means SCSI-to-host and 0 means host-to-SCSI. Bit 5 enables the ready interrupt, bit 4 enables core interrupts and bit 3 selects interrupt sharing; these three are read/write. Bit 2 is host-buffer-not-ready, bit 1 is SCSI-buffer-ready and bit 0 is the gated completion interrupt; these three are read-only.

## Requirements
- R1: After reset, control/status reads 0x84, the count reads 0, `irq` is low, and both `scsiInReady` and `scsiOutValid` are low.
- R2: Bits 6, 5, 4 and 3 of control/status read back as written. Writes to bits 2, 1 and 0 have no effect.
- R3: Writing a nonzero count while idle starts a transfer. Bit 7 clears and the count reads back the loaded value. A count write during a transfer is ignored.
- R4: In read direction, the SCSI side owns the buffer first. While it does, `scsiInReady` is high, and bit 1 is set and bit 2 is set. After the SCSI side has accepted `BLK_BYTES` bytes, bits 2 and 1 clear. Window offset i then returns the i-th byte accepted in that block.
- R5: In read direction, the `BLK_BYTES`-th window read decrements the count by one. If the count is still nonzero, the buffer returns to the SCSI side and status shows bits 2 and 1 set.
- R6: In write direction, bit 2 is clear at the start and `scsiOutValid` stays low until the host has written `BLK_BYTES` window bytes. The bytes are then presented on `scsiOutData` in window-offset order.
- R7: In write direction, the count decrements by one when the SCSI side drains the last byte of a block, and the host regains the buffer (bit 2 clear).
- R8: When the count reaches zero, bit 7 and bit 2 set and bit 1 clears. Bit 0 and `irq` go high only if bit 4 was set.
- R9: While bit 5 is set and the host owns the buffer during a transfer, `irq` is high.
- R10: While `scsiPause` is high, and afterwards until a write to 0x02, the SCSI handshake is idle and the count holds. After the resume write, bytes continue from the current buffer position.
- R11: Writing control/status with bit 7 set aborts any transfer and returns the block to the R1 state.
- R12: Window accesses in the wrong direction for the transfer do not change buffer contents and do not count toward the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe, one access per cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Register or window address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, combinational from address |
| scsiInValid | input | 1 | SCSI-side byte offered (read direction) |
| scsiInData | input | 8 | SCSI-side byte in |
| scsiInReady | output | 1 | Buffer accepts a SCSI byte |
| scsiOutValid | output | 1 | Buffer offers a byte to the SCSI side (write direction) |
| scsiOutData | output | 8 | Byte to the SCSI side |
| scsiOutReady | input | 1 | SCSI side takes the offered byte |
| scsiPause | input | 1 | Disconnect: halts the handshake until resumed |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the ownership hand-offs at the last byte of each block. A design that is off by one there would return a not-ready status a byte early or late, or would send a block to the SCSI side with one byte missing. Wrong-direction window writes in the middle of a read block must neither corrupt data nor advance the byte count; a design that counted them would hand the buffer back one read too soon. The bench pauses a drain in the middle of a block and then resumes it. The bench checks that the byte stream continues without a gap or repeat, which a design that rewound its index on resume would break. It also checks that the completion interrupt respects its enable and that an abort clears every state bit.

// File: rtl/blkdma_pkg.sv
`timescale 1ns/1ps
package blkdma_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_COUNT  = 1;
  localparam int unsigned REG_RESUME = 2;

  // control/status bit positions
  localparam int unsigned BIT_ACCESS = 7;
  localparam int unsigned BIT_DIR    = 6;
  localparam int unsigned BIT_RDYIE  = 5;
  localparam int unsigned BIT_COREIE = 4;
  localparam int unsigned BIT_SHARE  = 3;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic clrAll;
    logic clrIdx;
    logic scsiPush;
    logic scsiPop;
    logic hostWr;
    logic hostTick;
  } dpStrobe_t;
endpackage

// File: rtl/blkdma_datapath.sv
`timescale 1ns/1ps
module blkdma_datapath
  import blkdma_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic [7:0]       hostWdata,
  input  logic [7:0]       scsiInData,
  output logic [7:0]       winRdata,
  output logic [7:0]       scsiOutData,
  output logic [CNT_W-1:0] blkCnt,
  output logic             scsiLast,
  output logic             hostLast,
  output logic             cntOne
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  logic [7:0]       buffer [BLK_BYTES];
  logic [IDX_W-1:0] scsiIdx;
  logic [IDX_W-1:0] hostCnt;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  // single write port: only the owning side ever strobes
  always_ff @(posedge clk) begin
    if (stb.scsiPush)    buffer[scsiIdx] <= scsiInData;
    else if (stb.hostWr) buffer[hostIdx] <= hostWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scsiIdx <= '0;
      hostCnt <= '0;
      blkCnt  <= '0;
    end else if (stb.clrAll) begin
      scsiIdx <= '0;
      hostCnt <= '0;
      blkCnt  <= '0;
    end else begin
      if (stb.clrIdx) begin
        scsiIdx <= '0;
        hostCnt <= '0;
      end else begin
        if (stb.scsiPush || stb.scsiPop) scsiIdx <= stepIdx(scsiIdx);
        if (stb.hostTick)                hostCnt <= stepIdx(hostCnt);
      end
      if (stb.loadCnt)     blkCnt <= CNT_W'(hostWdata);
      else if (stb.decCnt) blkCnt <= blkCnt - 1'b1;
    end
  end

  assign winRdata    = buffer[hostIdx];
  assign scsiOutData = buffer[scsiIdx];
  assign scsiLast    = (scsiIdx == LAST_IDX);
  assign hostLast    = (hostCnt == LAST_IDX);
  assign cntOne      = (blkCnt == CNT_W'(1));
endmodule

// File: rtl/blkdma_ctrl.sv
`timescale 1ns/1ps
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic              scsiInValid,
  output logic              scsiInReady,
  output logic              scsiOutValid,
  input  logic              scsiOutReady,
  input  logic              scsiPause,
  input  logic [7:0]        winRdata,
  input  logic [CNT_W-1:0]  blkCnt,
  input  logic              scsiLast,
  input  logic              hostLast,
  input  logic              cntOne,
  output dpStrobe_t         stb,
  output logic              irq,
  output logic              busy,
  output logic              ownerHost,
  output logic              halted
);
  logic dirRead, rdyIe, coreIe, shareEn, gatedIrq, xferRead;
  logic winHit, ctrlWr, resetWr, cntWr, resumeWr, startXfer;
  logic hostOwns, scsiOwns, scsiGo, push, pop, hostTick;
  logic blockDone, finish, toHost, toScsi;
  logic [7:0] status;

  assign winHit    = hostSel && hostAddr[ADDR_W-1];
  assign ctrlWr    = hostSel && hostWr && (hostAddr == ADDR_W'(REG_CTRL));
  assign cntWr     = hostSel && hostWr && (hostAddr == ADDR_W'(REG_COUNT));
  assign resumeWr  = hostSel && hostWr && (hostAddr == ADDR_W'(REG_RESUME));
  assign resetWr   = ctrlWr && hostWdata[BIT_ACCESS];
  assign startXfer = cntWr && !busy && (CNT_W'(hostWdata) != '0);

  assign hostOwns = busy && ownerHost;
  assign scsiOwns = busy && !ownerHost;
  assign scsiGo   = scsiOwns && !halted && !scsiPause;

  assign scsiInReady  = scsiGo && xferRead;
  assign scsiOutValid = scsiGo && !xferRead;
  assign push = scsiInReady && scsiInValid;
  assign pop  = scsiOutValid && scsiOutReady;
  // host moves data only the way the transfer runs
  assign hostTick = winHit && hostOwns && (hostWr != xferRead);

  assign blockDone = (pop && scsiLast) || (hostTick && xferRead && hostLast);
  assign finish    = blockDone && cntOne;
  assign toHost    = push && scsiLast;
  assign toScsi    = hostTick && hostLast;

  always_comb begin
    stb          = '0;
    stb.loadCnt  = cntWr && !busy;
    stb.decCnt   = blockDone;
    stb.clrAll   = resetWr;
    stb.clrIdx   = startXfer;
    stb.scsiPush = push;
    stb.scsiPop  = pop;
    stb.hostWr   = hostTick && hostWr;
    stb.hostTick = hostTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || resetWr) begin
      {dirRead, rdyIe, coreIe, shareEn} <= '0;
      {busy, ownerHost, halted, gatedIrq, xferRead} <= '0;
    end else begin
      if (ctrlWr) begin
        dirRead <= hostWdata[BIT_DIR];
        rdyIe   <= hostWdata[BIT_RDYIE];
        coreIe  <= hostWdata[BIT_COREIE];
        shareEn <= hostWdata[BIT_SHARE];
      end
      if (startXfer) begin
        busy      <= 1'b1;
        xferRead  <= dirRead;
        ownerHost <= !dirRead;
        gatedIrq  <= 1'b0;
        halted    <= 1'b0;
      end else begin
        halted <= busy && (scsiPause || (halted && !resumeWr));
        if (finish) begin
          busy     <= 1'b0;
          gatedIrq <= coreIe;
        end else if (toHost || (pop && scsiLast)) begin
          ownerHost <= 1'b1;
        end else if (toScsi) begin
          ownerHost <= 1'b0;
        end
      end
    end
  end

  assign status = {!busy, dirRead, rdyIe, coreIe, shareEn, !hostOwns, scsiOwns, gatedIrq};
  assign irq    = gatedIrq || (rdyIe && hostOwns);

  always_comb begin
    if (winHit)                                  hostRdata = winRdata;
    else if (hostAddr == ADDR_W'(REG_CTRL))      hostRdata = status;
    else if (hostAddr == ADDR_W'(REG_COUNT))     hostRdata = 8'(blkCnt);
    else                                         hostRdata = 8'h00;
  end
endmodule

// File: rtl/blkdma_bridge.sv
`timescale 1ns/1ps
module blkdma_bridge
  import blkdma_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic              scsiInValid,
  input  logic [7:0]        scsiInData,
  output logic              scsiInReady,
  output logic              scsiOutValid,
  output logic [7:0]        scsiOutData,
  input  logic              scsiOutReady,
  input  logic              scsiPause,
  output logic              irq
);
  dpStrobe_t        stb;
  logic [7:0]       winRdata;
  logic [CNT_W-1:0] blkCnt;
  logic             scsiLast, hostLast, cntOne;
  logic             busy, ownerHost, halted;

  blkdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .scsiInValid(scsiInValid), .scsiInReady(scsiInReady),
    .scsiOutValid(scsiOutValid), .scsiOutReady(scsiOutReady),
    .scsiPause(scsiPause), .winRdata(winRdata), .blkCnt(blkCnt),
    .scsiLast(scsiLast), .hostLast(hostLast), .cntOne(cntOne),
    .stb(stb), .irq(irq), .busy(busy), .ownerHost(ownerHost),
    .halted(halted)
  );

  blkdma_datapath #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostIdx(hostAddr[IDX_W-1:0]), .hostWdata(hostWdata),
    .scsiInData(scsiInData), .winRdata(winRdata),
    .scsiOutData(scsiOutData), .blkCnt(blkCnt),
    .scsiLast(scsiLast), .hostLast(hostLast), .cntOne(cntOne)
  );
endmodule

// File: rtl/blkdma_bridge_chk.sv
`timescale 1ns/1ps
module blkdma_bridge_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostSel,
  input logic             hostWr,
  input logic             scsiInReady,
  input logic             scsiOutValid,
  input logic             scsiPause,
  input logic             busy,
  input logic             ownerHost,
  input logic             halted,
  input logic [CNT_W-1:0] blkCnt
);
  p_one_way_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(scsiInReady && scsiOutValid));

  p_pause_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    scsiPause |-> (!scsiInReady && !scsiOutValid));

  p_halt_holds_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (halted && busy && !ownerHost && !(hostSel && hostWr)) |=> $stable(blkCnt));

  p_done_at_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (blkCnt == '0));

  p_step_by_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(hostSel && hostWr)) |=>
      (blkCnt == $past(blkCnt) || blkCnt == ($past(blkCnt) - CNT_W'(1))));
endmodule

bind blkdma_bridge blkdma_bridge_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
  .scsiInReady(scsiInReady), .scsiOutValid(scsiOutValid),
  .scsiPause(scsiPause), .busy(busy), .ownerHost(ownerHost),
  .halted(halted), .blkCnt(blkCnt)
);

// File: tb/blkdma_bridge_test.sv
`timescale 1ns/1ps
module blkdma_bridge_test;
  localparam int BLK = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSel = 1'b0, hostWr = 1'b0;
  logic [7:0] hostAddr = 8'h00, hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       scsiInValid = 1'b0;
  logic [7:0] scsiInData = 8'h00;
  logic       scsiInReady, scsiOutValid;
  logic [7:0] scsiOutData;
  logic       scsiOutReady = 1'b0, scsiPause = 1'b0;
  logic       irq;

  int checks = 0, failures = 0, drained = 0;
  logic [7:0] rdQ[$];
  logic [7:0] wrQ[$];

  blkdma_bridge uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .scsiInValid(scsiInValid), .scsiInData(scsiInData),
    .scsiInReady(scsiInReady), .scsiOutValid(scsiOutValid),
    .scsiOutData(scsiOutData), .scsiOutReady(scsiOutReady),
    .scsiPause(scsiPause), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk);
    #0.5 hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    @(posedge clk);
    #0.5 hostSel = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    hostRead(a, v);
    chk(tag, v, exp);
  endtask

  // driver: offers one byte and records it as the expected window content
  task automatic scsiPush(input logic [7:0] b);
    @(negedge clk);
    scsiInValid = 1'b1; scsiInData = b;
    while (!scsiInReady) @(negedge clk);
    rdQ.push_back(b);
    @(posedge clk);
    #0.5 scsiInValid = 1'b0;
  endtask

  // read one window byte and compare with the scoreboard
  task automatic windowPop(input int idx, input string tag);
    logic [7:0] v;
    logic [7:0] e;
    hostRead(8'h80 | 8'(idx), v);
    e = (rdQ.size() > 0) ? rdQ.pop_front() : 8'hxx;
    chk(tag, v, e);
  endtask

  // monitor: compares drained bytes against the host-written order
  always begin
    @(negedge clk);
    #1;
    if (rstN && scsiOutValid && scsiOutReady) begin
      drained++;
      if (wrQ.size() == 0) chk("R6 unexpected drain", scsiOutData, 8'hxx);
      else chk("R6 drain order", scsiOutData, wrQ.pop_front());
    end
  end

  initial begin
    #(4 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq", irq, 0);
    chk("R1 inReady", scsiInReady, 0);
    chk("R1 outValid", scsiOutValid, 0);
    expectReg("R1 status", 8'h00, 8'h84);
    expectReg("R1 count", 8'h01, 8'h00);

    hostWrite(8'h00, 8'h38);
    expectReg("R2 enables readback", 8'h00, 8'hBC);
    hostWrite(8'h00, 8'h7F);
    expectReg("R2 status bits not writable", 8'h00, 8'hFC);

    // ---- read direction, two blocks
    hostWrite(8'h00, 8'h50);
    hostWrite(8'h01, 8'h02);
    expectReg("R3 started", 8'h00, 8'h56);
    expectReg("R3 count loaded", 8'h01, 8'h02);
    hostWrite(8'h01, 8'h09);
    expectReg("R3 count write ignored while busy", 8'h01, 8'h02);
    @(negedge clk); #1;
    chk("R4 inReady while SCSI owns", scsiInReady, 1);
    for (int i = 0; i < BLK; i++) scsiPush(8'(i * 3 + 1));
    expectReg("R4 handed to host", 8'h00, 8'h50);
    @(negedge clk); #1;
    chk("R4 inReady low after fill", scsiInReady, 0);
    hostWrite(8'h85, 8'hEE);  // wrong direction
    for (int i = 0; i < BLK - 1; i++) windowPop(i, "R4 read data");
    expectReg("R12 stray write not counted", 8'h00, 8'h50);
    windowPop(BLK - 1, "R4 last byte");
    expectReg("R5 count decremented", 8'h01, 8'h01);
    expectReg("R5 buffer back to SCSI", 8'h00, 8'h56);

    hostWrite(8'h00, 8'h70);
    for (int i = 0; i < BLK; i++) scsiPush(~8'(i));
    @(negedge clk); #1;
    chk("R9 ready irq", irq, 1);
    expectReg("R9 status host owns", 8'h00, 8'h70);
    for (int i = 0; i < BLK; i++) windowPop(i, "R4 block2 data");
    expectReg("R8 done with irq", 8'h00, 8'hF5);
    expectReg("R8 count zero", 8'h01, 8'h00);
    @(negedge clk); #1;
    chk("R8 irq high", irq, 1);

    // ---- write direction, two blocks
    hostWrite(8'h00, 8'h00);
    scsiOutReady = 1'b1;
    hostWrite(8'h01, 8'h02);
    expectReg("R6 host owns at start", 8'h00, 8'h00);
    @(negedge clk); #1;
    chk("R8 gated irq cleared", irq, 0);
    for (int i = 0; i < BLK; i++) begin
      wrQ.push_back(8'(i) ^ 8'h5A);
      hostWrite(8'h80 | 8'(i), 8'(i) ^ 8'h5A);
      if (i == BLK - 2) begin
        @(negedge clk); #1;
        chk("R6 no drain before full", scsiOutValid, 0);
      end
    end
    while (drained < BLK) @(negedge clk);
    repeat (2) @(negedge clk);
    expectReg("R7 count after drain", 8'h01, 8'h01);
    expectReg("R7 host regains buffer", 8'h00, 8'h00);

    scsiOutReady = 1'b0;
    for (int i = 0; i < BLK; i++) begin
      wrQ.push_back(8'(i * 7));
      hostWrite(8'h80 | 8'(i), 8'(i * 7));
    end
    scsiOutReady = 1'b1;
    while (drained < BLK + 20) @(negedge clk);
    scsiPause = 1'b1;
    snap = drained;
    repeat (4) @(negedge clk);
    #1 chk("R10 valid low in pause", scsiOutValid, 0);
    scsiPause = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk("R10 held until resume", scsiOutValid, 0);
    chk("R10 nothing drained", drained, snap);
    expectReg("R10 count held", 8'h01, 8'h01);
    hostWrite(8'h02, 8'h00);
    while (drained < 2 * BLK) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 resume completes block", drained, 2 * BLK);
    expectReg("R8 done without irq", 8'h00, 8'h84);
    @(negedge clk); #1;
    chk("R8 irq stays low", irq, 0);
    scsiOutReady = 1'b0;

    // ---- abort
    hostWrite(8'h00, 8'h50);
    hostWrite(8'h01, 8'h03);
    for (int i = 0; i < 10; i++) scsiPush(8'(i));
    hostWrite(8'h00, 8'h80);
    expectReg("R11 status after abort", 8'h00, 8'h84);
    expectReg("R11 count after abort", 8'h01, 8'h00);
    @(negedge clk); #1;
    chk("R11 inReady after abort", scsiInReady, 0);
    chk("R11 irq after abort", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule